// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block drives the horizontal sync, vertical sync and display-enable lines of a parallel RGB LCD panel. It advances one position per pixel clock. Two positions are kept: a line position that counts pixel clocks within a line, and a frame position that counts pixel clocks from the start of the frame. Vertical timing is expressed as absolute pixel-clock offsets in the frame rather than as line numbers. Software converts line counts into these offsets: it multiplies each line count by the line period and then adds the skew.

Configuration comes through a small write port with a 3-bit address and a 32-bit data word. Writes to the timing registers go into a pending set. That set is copied into the active set when the raster starts and at every frame start, so a frame always completes with the values it began with. Bit 0 of the control register starts and stops the raster. Software writes that bit last, after the timing registers.

Top module: `lcdtg_raster`

## Requirements
- R1: After reset, and at any time the run bit is clear, hsync, vsync and de stay low. Writing the timing registers alone does not start the raster.
- R2: The line period is taken from bits 31:16 of address 1 and the hsync width from bits 15:0 of address 1. hsync is high for line positions 0 to width−1. The line position returns to 0 after it reaches period−1.
- R3: The frame period is programmed at address 2 and the vsync width at address 3, both in pixel clocks. The skew is bits 15:0 of address 7. vsync is high while the frame position p satisfies skew ≤ p < skew + width. The frame position returns to 0 after it reaches period−1.
- R4: de is high only when both of these hold. The frame position lies between the vertical start (address 5) and the vertical end (address 6), bounds included. The line position lies between the horizontal start (bits 15:0 of address 4) and the horizontal end (bits 31:16 of address 4), bounds included.
- R5: At every frame start the line position also restarts at 0, even when the frame period is not a multiple of the line period.
- R6: A timing write made while the raster runs has no effect until the first clock of the next frame. The current frame completes with the old values.
- R7: Writing 1 to bit 0 of address 0 while the raster is stopped does two things at that edge: it loads the pending timing, and the outputs after that edge show frame position 0 and line position 0. Writing 1 while the raster runs changes nothing.
- R8: Writing 0 to bit 0 of address 0 stops the raster. From the next edge all outputs are low and both positions are 0. A later start begins again at position 0.
- R9: The reset timing describes a 480×800 active area. The hsync pulse is 8 clocks, the horizontal back porch 184 and the horizontal front porch 4. The vsync pulse is 1 line, the vertical back porch 2 lines, the vertical front porch 3 lines, and the skew is 0. From these the block derives: line period 676, horizontal window 192..671, frame period 544856, vsync width 676, vertical window 2028..542827.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 control, 1 line word, 2 frame period, 3 vsync width, 4 horizontal window, 5 vertical start, 6 vertical end, 7 skew) |
| wr_data | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Display enable, active high |

## Verification
The raster is first run from the reset timing long enough to cover the first active pixel at frame position 2220. This confirms the derived default offsets, as distinct from the porch values they are built from. A small timing set then checks several things over more than one frame: its frame period is not a multiple of the line period, which shows whether the line position restarts at frame start, and its nonzero skew separates vsync placement from frame position 0. A second set is written in the middle of a frame to show whether it is deferred to the next frame. Start-while-running, stop, and restart patterns show whether the run bit resets the positions only when it should.

// File: rtl/lcdtg_pkg.sv
package lcdtg_pkg;

    localparam int LINE_W  = 16;
    localparam int FRAME_W = 32;
    localparam int ADDR_W  = 3;
    localparam int DATA_W  = 32;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_HWORD  = 3'd1,
        RA_FPER   = 3'd2,
        RA_VPW    = 3'd3,
        RA_HACT   = 3'd4,
        RA_VSTART = 3'd5,
        RA_VEND   = 3'd6,
        RA_SKEW   = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic [LINE_W-1:0]  hper;
        logic [LINE_W-1:0]  hpw;
        logic [LINE_W-1:0]  hstart;
        logic [LINE_W-1:0]  hend;
        logic [LINE_W-1:0]  skew;
        logic [FRAME_W-1:0] fper;
        logic [FRAME_W-1:0] vpw;
        logic [FRAME_W-1:0] vstart;
        logic [FRAME_W-1:0] vend;
    } tcfg_t;

endpackage

// File: rtl/lcdtg_regs.sv
module lcdtg_regs
    import lcdtg_pkg::*;
#(
    parameter tcfg_t DEF_CFG = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              frame_end,
    output logic              run_n,
    output logic              start,
    output tcfg_t             cfg_q,
    output tcfg_t             cfg_n
);

    typedef struct packed {
        logic  run;
        tcfg_t pend;
        tcfg_t act;
    } regs_t;

    regs_t d, q;
    logic  load;

    always_comb begin
        d     = q;
        run_n = q.run;
        if (wr_en && reg_addr_e'(wr_addr) == RA_CTRL) begin
            run_n = wr_data[0];
        end
        start = run_n & ~q.run;
        load  = start | (q.run & run_n & frame_end);
        cfg_n = load ? q.pend : q.act;
        d.run = run_n;
        d.act = cfg_n;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_HWORD: begin
                    d.pend.hper = wr_data[2*LINE_W-1:LINE_W];
                    d.pend.hpw  = wr_data[LINE_W-1:0];
                end
                RA_FPER:   d.pend.fper   = wr_data[FRAME_W-1:0];
                RA_VPW:    d.pend.vpw    = wr_data[FRAME_W-1:0];
                RA_HACT: begin
                    d.pend.hstart = wr_data[LINE_W-1:0];
                    d.pend.hend   = wr_data[2*LINE_W-1:LINE_W];
                end
                RA_VSTART: d.pend.vstart = wr_data[FRAME_W-1:0];
                RA_VEND:   d.pend.vend   = wr_data[FRAME_W-1:0];
                RA_SKEW:   d.pend.skew   = wr_data[LINE_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.run  <= 1'b0;
            q.pend <= DEF_CFG;
            q.act  <= DEF_CFG;
        end else begin
            q <= d;
        end
    end

    assign cfg_q = q.act;

    // R6: the active timing moves only on a load
    a_r6_active_held: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q.act));

    // R7: a start copies the pending set into the active set
    a_r7_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (q.act == $past(q.pend)));

endmodule

// File: rtl/lcdtg_counters.sv
module lcdtg_counters
    import lcdtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_n,
    input  logic               start,
    input  logic [LINE_W-1:0]  hper,
    input  logic [FRAME_W-1:0] fper,
    output logic               frame_end,
    output logic [LINE_W-1:0]  hpos_n,
    output logic [FRAME_W-1:0] fpos_n
);

    typedef struct packed {
        logic [LINE_W-1:0]  h;
        logic [FRAME_W-1:0] f;
    } pos_t;

    pos_t d, q;
    logic line_end;

    always_comb begin
        line_end  = ((LINE_W+1)'(q.h) + (LINE_W+1)'(1)) >= (LINE_W+1)'(hper);
        frame_end = ((FRAME_W+1)'(q.f) + (FRAME_W+1)'(1)) >= (FRAME_W+1)'(fper);
        d = q;
        if (!run_n || start || frame_end) begin
            d = '0;
        end else begin
            d.h = line_end ? '0 : q.h + LINE_W'(1);
            d.f = q.f + FRAME_W'(1);
        end
        hpos_n = d.h;
        fpos_n = d.f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R5: a frame boundary zeroes both positions
    a_r5_frame_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (run_n && !start && frame_end) |=> (q.f == '0 && q.h == '0));

    // R2: line position stays inside the programmed period
    a_r2_line_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (hper != '0) |-> (q.h < hper));

    // R8: a stopped raster holds both positions at zero
    a_r8_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_n |=> (q.f == '0 && q.h == '0));

endmodule

// File: rtl/lcdtg_outgen.sv
module lcdtg_outgen
    import lcdtg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_n,
    input  logic [LINE_W-1:0]  hpos_n,
    input  logic [FRAME_W-1:0] fpos_n,
    input  logic [LINE_W-1:0]  hpw,
    input  logic [LINE_W-1:0]  hstart,
    input  logic [LINE_W-1:0]  hend,
    input  logic [LINE_W-1:0]  skew,
    input  logic [FRAME_W-1:0] vpw,
    input  logic [FRAME_W-1:0] vstart,
    input  logic [FRAME_W-1:0] vend,
    output logic               hsync,
    output logic               vsync,
    output logic               de
);

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } outs_t;

    outs_t d, q;
    logic  in_vs, in_vwin, in_hwin;

    always_comb begin
        in_vs   = (fpos_n >= FRAME_W'(skew)) &&
                  ((FRAME_W+1)'(fpos_n) <
                   ((FRAME_W+1)'(skew) + (FRAME_W+1)'(vpw)));
        in_vwin = (fpos_n >= vstart) && (fpos_n <= vend);
        in_hwin = (hpos_n >= hstart) && (hpos_n <= hend);
        d.hs    = run_n && (hpos_n < hpw);
        d.vs    = run_n && in_vs;
        d.de    = run_n && in_vwin && in_hwin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign hsync = q.hs;
    assign vsync = q.vs;
    assign de    = q.de;

    // R1 / R8: nothing is driven while the raster is stopped
    a_r8_quiet_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !run_n |=> !(hsync || vsync || de));

endmodule

// File: rtl/lcdtg_raster.sv
module lcdtg_raster
    import lcdtg_pkg::*;
#(
    parameter int H_ACTIVE = 480,
    parameter int H_PULSE  = 8,
    parameter int H_BACK   = 184,
    parameter int H_FRONT  = 4,
    parameter int V_ACTIVE = 800,
    parameter int V_PULSE  = 1,
    parameter int V_BACK   = 2,
    parameter int V_FRONT  = 3,
    parameter int SKEW     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              de
);

    localparam int H_PERIOD = H_PULSE + H_BACK + H_ACTIVE + H_FRONT;
    localparam int V_LINES  = V_PULSE + V_BACK + V_ACTIVE + V_FRONT;
    localparam int F_PERIOD = H_PERIOD * V_LINES;
    localparam int H_START  = H_PULSE + H_BACK;
    localparam int H_END    = H_START + H_ACTIVE - 1;
    localparam int V_START  = (V_PULSE + V_BACK) * H_PERIOD + SKEW;
    localparam int V_END    = F_PERIOD - V_FRONT * H_PERIOD + SKEW - 1;

    localparam tcfg_t DEF_CFG = '{
        hper:   LINE_W'(H_PERIOD),
        hpw:    LINE_W'(H_PULSE),
        hstart: LINE_W'(H_START),
        hend:   LINE_W'(H_END),
        skew:   LINE_W'(SKEW),
        fper:   FRAME_W'(F_PERIOD),
        vpw:    FRAME_W'(V_PULSE * H_PERIOD),
        vstart: FRAME_W'(V_START),
        vend:   FRAME_W'(V_END)
    };

    logic               run_n, start, frame_end;
    tcfg_t              cfg_q, cfg_n;
    logic [LINE_W-1:0]  hpos_n;
    logic [FRAME_W-1:0] fpos_n;

    lcdtg_regs #(.DEF_CFG(DEF_CFG)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .run_n     (run_n),
        .start     (start),
        .cfg_q     (cfg_q),
        .cfg_n     (cfg_n)
    );

    lcdtg_counters u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_n     (run_n),
        .start     (start),
        .hper      (cfg_q.hper),
        .fper      (cfg_q.fper),
        .frame_end (frame_end),
        .hpos_n    (hpos_n),
        .fpos_n    (fpos_n)
    );

    lcdtg_outgen u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_n  (run_n),
        .hpos_n (hpos_n),
        .fpos_n (fpos_n),
        .hpw    (cfg_n.hpw),
        .hstart (cfg_n.hstart),
        .hend   (cfg_n.hend),
        .skew   (cfg_n.skew),
        .vpw    (cfg_n.vpw),
        .vstart (cfg_n.vstart),
        .vend   (cfg_n.vend),
        .hsync  (hsync),
        .vsync  (vsync),
        .de     (de)
    );

endmodule

// File: tb/lcdtg_raster_test.sv
module lcdtg_raster_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        hsync, vsync, de;

    lcdtg_raster uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hsync   (hsync),
        .vsync   (vsync),
        .de      (de)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    typedef struct {
        bit    hs;
        bit    vs;
        bit    de;
        string tag;
    } exp_t;

    exp_t sb[$];

    // model timing: 0 hper,1 hpw,2 fper,3 vpw,4 hstart,5 hend,6 vstart,7 vend,8 skew
    longint m_pend[9];
    longint m_act[9];
    bit     m_run = 0;
    longint m_f = 0;
    longint m_h = 0;

    task automatic report;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic check_bit(input string what, input bit got, input bit exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got %b expected %b", what, got, exp);
        end
    endtask

    // driver: applies one cycle of stimulus and queues the expected outputs
    task automatic step(input bit we, input logic [2:0] a, input logic [31:0] d,
                        input string tag);
        bit   nrun, st, fe, ld;
        exp_t e;
        @(negedge clk);
        #1;
        wr_en = we; wr_addr = a; wr_data = d;
        nrun = m_run;
        if (we && a == 3'd0) nrun = d[0];
        st = nrun && !m_run;
        fe = m_run && (m_f + 1 >= m_act[2]);
        ld = st || (m_run && nrun && fe);
        if (ld) m_act = m_pend;
        if (!nrun || st || fe) begin
            m_f = 0; m_h = 0;
        end else begin
            m_f = m_f + 1;
            m_h = (m_h + 1 >= m_act[0]) ? 0 : m_h + 1;
        end
        if (we) begin
            case (a)
                3'd1: begin m_pend[0] = d[31:16]; m_pend[1] = d[15:0]; end
                3'd2: m_pend[2] = d;
                3'd3: m_pend[3] = d;
                3'd4: begin m_pend[4] = d[15:0]; m_pend[5] = d[31:16]; end
                3'd5: m_pend[6] = d;
                3'd6: m_pend[7] = d;
                3'd7: m_pend[8] = d[15:0];
                default: ;
            endcase
        end
        e.hs  = nrun && (m_h < m_act[1]);
        e.vs  = nrun && (m_f >= m_act[8]) && (m_f < m_act[8] + m_act[3]);
        e.de  = nrun && (m_f >= m_act[6]) && (m_f <= m_act[7]) &&
                (m_h >= m_act[4]) && (m_h <= m_act[5]);
        e.tag = tag;
        m_run = nrun;
        sb.push_back(e);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 3'd0, 32'd0, tag);
    endtask

    // monitor: compares each queued item one edge after it was queued
    always @(negedge clk) begin
        exp_t e;
        if (sb.size() > 0) begin
            e = sb.pop_front();
            check_bit({e.tag, " R2 hsync"}, hsync, e.hs);
            check_bit({e.tag, " R3 vsync"}, vsync, e.vs);
            check_bit({e.tag, " R4 de"},    de,    e.de);
        end
    end

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog expired, got running expected finished");
        report();
    end

    initial begin
        m_pend = '{676, 8, 544856, 676, 192, 671, 2028, 542827, 0};
        m_act  = m_pend;
        repeat (3) @(negedge clk);
        check_bit("R1 reset hsync", hsync, 1'b0);
        check_bit("R1 reset vsync", vsync, 1'b0);
        check_bit("R1 reset de",    de,    1'b0);
        rst_n = 1'b1;
        idle(5, "R1");
        // R7 start and R9 reset timing up to the first active pixel (2220)
        step(1'b1, 3'd0, 32'd1, "R7");
        idle(2300, "R9");
        // R8 stop
        step(1'b1, 3'd0, 32'd0, "R8");
        idle(5, "R8");
        // R1 timing writes while stopped start nothing
        step(1'b1, 3'd1, {16'd10, 16'd2}, "R1");
        step(1'b1, 3'd2, 32'd57, "R1");
        step(1'b1, 3'd3, 32'd20, "R1");
        step(1'b1, 3'd4, {16'd7, 16'd3}, "R1");
        step(1'b1, 3'd5, 32'd23, "R1");
        step(1'b1, 3'd6, 32'd45, "R1");
        step(1'b1, 3'd7, 32'd3, "R1");
        idle(3, "R1");
        // R7 restart, R5 frame of 57 not a multiple of 10
        step(1'b1, 3'd0, 32'd1, "R7");
        idle(60, "R2");
        idle(70, "R5");
        // R7 start while running has no effect
        step(1'b1, 3'd0, 32'd1, "R7");
        idle(20, "R7");
        // R6 mid-frame reprogramming deferred to next frame
        step(1'b1, 3'd1, {16'd8, 16'd3}, "R6");
        step(1'b1, 3'd7, 32'd0, "R6");
        step(1'b1, 3'd3, 32'd16, "R6");
        step(1'b1, 3'd2, 32'd40, "R6");
        step(1'b1, 3'd5, 32'd8, "R6");
        step(1'b1, 3'd6, 32'd35, "R6");
        step(1'b1, 3'd4, {16'd6, 16'd2}, "R6");
        idle(150, "R6");
        // R8 stop then restart from position 0
        step(1'b1, 3'd0, 32'd0, "R8");
        idle(4, "R8");
        step(1'b1, 3'd0, 32'd1, "R7");
        idle(50, "R3");
        repeat (3) @(negedge clk);
        report();
    end

endmodule